// File: doc/BRIEF.md
# Selectable-Ratio Bus Clock Divider

This block produces a slower peripheral bus clock from the processor bus clock. It outputs a divided clock, `clk_div`, and a one-cycle `tick` at each rising edge of that clock. A 3-bit ratio field sits in bits 6 to 4 of an 8-bit control value, which is loaded by a write strobe. Seven of the eight codes select a divisor. The mapping is not monotonic, and it mixes even divisors (2, 4, 6, 8, 10) with odd ones (3, 5).

The remaining code, 011, selects a separate fixed-frequency source of roughly 7.16 MHz. That source is generated elsewhere and arrives as the enable `alt_en`. In this mode `tick` carries the external enable and `clk_div` stays low. The fixed source is also the mode after reset, and it stays selected until the first write.

A new ratio is staged when it is written. It is applied only when the running output period ends, so no shortened high or low phase is ever produced. The only exception is a change made while the fixed source is selected: the divider is idle then, so the new ratio starts straight away.

Top module: `bus_clk_divider`

## Requirements
- R1: During and after reset, `clk_div` and `tick` are low, the divider counter is zero and the fixed source (code 011) is selected.
- R2: Ratio code 000 gives a period of 2 input cycles, 001 gives 4 and 010 gives 8.
- R3: Ratio code 100 gives a period of 3 input cycles, 101 gives 6, 110 gives 5 and 111 gives 10.
- R4: Code 011 selects the fixed source. `clk_div` is held low, and `tick` equals `alt_en` delayed by one input clock.
- R5: Within each period of N cycles, `clk_div` is low for ceil(N/2) cycles first and then high for floor(N/2) cycles.
- R6: `tick` is high for exactly one input clock at each rising edge of `clk_div`, in the first high cycle.
- R7: A ratio written while dividing takes effect only after the current period ends. The interval from the last old tick to the first new tick is (N_old - ceil(N_old/2)) + ceil(N_new/2) cycles.
- R8: A ratio written while the fixed source is selected is applied one cycle after the write, with the counter starting from zero. The first tick follows ceil(N/2) cycles later.
- R9: Only bits 6 to 4 of `cfg_data` take part, and only while `cfg_wr` is high. All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control value |
| cfg_data | input | 8 | Control value; ratio code in bits 6:4 |
| alt_en | input | 1 | Enable from the fixed-frequency source |
| clk_div | output | 1 | Divided bus clock |
| tick | output | 1 | One-cycle pulse at each rising edge of `clk_div` |

## Verification
The divider is driven through all seven divisor codes. For each code the period, the high-phase length and the tick count are measured, which separates the even and odd ratios and exposes any entry of the non-monotonic mapping that is swapped. Two of the codes are written with unrelated bits set, to show that those bits are ignored. A ratio change is issued right after a tick. The measured interval tells a change applied at the period boundary apart from one that truncates the running period. The fixed-source mode is checked both out of reset and on entry from a divisor, by toggling `alt_en` and by measuring how long the first tick takes after the divider is released from that mode.

// File: rtl/bus_clk_divider.sv
module bus_clk_divider #(
  parameter int          CTRL_W   = 8,
  parameter int          SEL_LSB  = 4,
  parameter int          CNT_W    = 4,
  parameter logic [2:0]  ALT_CODE = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_data,
  input  logic              alt_en,
  output logic              clk_div,
  output logic              tick
);

  localparam int SEL_W = 3;

  function automatic logic [CNT_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    case (code)
      3'b000:  ratio_of = CNT_W'(2);
      3'b001:  ratio_of = CNT_W'(4);
      3'b010:  ratio_of = CNT_W'(8);
      3'b100:  ratio_of = CNT_W'(3);
      3'b101:  ratio_of = CNT_W'(6);
      3'b110:  ratio_of = CNT_W'(5);
      3'b111:  ratio_of = CNT_W'(10);
      default: ratio_of = CNT_W'(1);
    endcase
  endfunction

  logic [SEL_W-1:0] pend_q, act_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx, n_act, hi_start;
  logic             clk_q, tick_q, alt_q, at_end;

  assign n_act    = ratio_of(act_q);
  assign hi_start = n_act - (n_act >> 1);
  assign alt_q    = (act_q == ALT_CODE);
  assign at_end   = (cnt_q == n_act - CNT_W'(1));
  assign cnt_nx   = (alt_q || at_end) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= ALT_CODE;
      act_q  <= ALT_CODE;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (cfg_wr) pend_q <= cfg_data[SEL_LSB +: SEL_W];
      if (alt_q || at_end) act_q <= pend_q;
      cnt_q  <= cnt_nx;
      clk_q  <= !alt_q && (cnt_nx >= hi_start);
      tick_q <= alt_q ? alt_en : (cnt_nx == hi_start);
    end
  end

  assign clk_div = clk_q;
  assign tick    = tick_q;

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < n_act);

  a_r4_alt_low: assert property (@(posedge clk) disable iff (!rst_n)
    alt_q |-> !clk_div);

  a_r4_alt_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(alt_q)) |-> (tick == $past(alt_en)));

  a_r6_tick_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_div) |-> tick);

  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_div) |=> !tick);

  a_r7_switch_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> ($past(at_end) || $past(alt_q)));

endmodule

// File: tb/tb_bus_clk_divider.sv
module tb_bus_clk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       alt_en = 1'b0;
  logic       clk_div, tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_clk_divider dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .alt_en(alt_en), .clk_div(clk_div), .tick(tick)
  );

  // {control byte, expected period}; tags R2, R3, R9
  localparam int NV = 9;
  localparam logic [7:0] VCTRL [NV] = '{8'h00, 8'h10, 8'h20, 8'h40, 8'h50,
                                        8'h60, 8'h70, 8'hCF, 8'hAF};
  localparam int VN [NV] = '{2, 4, 8, 3, 6, 5, 10, 3, 8};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    cfg_data = v;
    cfg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_data = 8'h00;
  endtask

  task automatic wait_tick(input string req);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!tick && k < 100);
    if (!tick) check(1'b0, req, 0, 1);
  endtask

  task automatic measure(input int n, input string req);
    int len = 0, hi = 0, tk = 0;
    do begin
      @(negedge clk);
      len++;
      hi += int'(clk_div);
      tk += int'(tick);
    end while (!tick && len < 100);
    check(len == n, {req, " period"}, len, n);
    check(hi == n / 2, {req, " R5 high phase"}, hi, n / 2);
    check(tk == 1, {req, " R6 tick count"}, tk, 1);
  endtask

  function automatic int ceil_half(input int n);
    return n - n / 2;
  endfunction

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(clk_div == 1'b0 && tick == 1'b0, "R1 reset outputs", {clk_div, tick}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: fixed source selected after reset, R4 follows alt_en
    alt_en = 1'b1;
    @(negedge clk);
    check(tick == 1'b1, "R1 fixed source after reset", tick, 1);
    check(clk_div == 1'b0, "R4 clk_div low in fixed mode", clk_div, 0);
    alt_en = 1'b0;
    @(negedge clk);
    check(tick == 1'b0, "R4 tick follows alt_en low", tick, 0);

    // R8: leaving the fixed source, N=5
    write_ctrl(8'h60);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!tick && k < 50);
    check(k == ceil_half(5) + 1, "R8 first tick latency", k, ceil_half(5) + 1);

    // R2 R3 R9: table walk
    for (int i = 0; i < NV; i++) begin
      write_ctrl(VCTRL[i]);
      wait_tick("R2/R3 sync");
      wait_tick("R2/R3 sync");
      measure(VN[i], (i < 3) ? "R2" : (i < 7) ? "R3" : "R9");
      measure(VN[i], (i < 3) ? "R2" : (i < 7) ? "R3" : "R9");
    end

    // R7: change 6 -> 3 right after a tick
    write_ctrl(8'h50);
    wait_tick("R7 sync");
    wait_tick("R7 sync");
    cfg_data = 8'h40;
    cfg_wr = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      cfg_wr = 1'b0;
      k++;
      if (k < 3) check(!(k < 3 && clk_div == 1'b0), "R7 old high phase kept", clk_div, 1);
    end while (!tick && k < 50);
    check(k == (6 - ceil_half(6)) + ceil_half(3), "R7 boundary interval", k,
          (6 - ceil_half(6)) + ceil_half(3));
    measure(3, "R7");

    // R9: strobe low has no effect
    cfg_data = 8'h00;
    repeat (12) @(negedge clk);
    wait_tick("R9 sync");
    measure(3, "R9 no strobe");

    // R4: entering the fixed source
    write_ctrl(8'h30);
    repeat (8) @(negedge clk);
    check(clk_div == 1'b0 && tick == 1'b0, "R4 entered fixed mode", {clk_div, tick}, 0);
    alt_en = 1'b1;
    @(negedge clk);
    alt_en = 1'b0;
    check(tick == 1'b1, "R4 tick on alt_en", tick, 1);
    @(negedge clk);
    check(tick == 1'b0 && clk_div == 1'b0, "R4 tick drops", tick, 0);

    // R1: reset mid-run
    write_ctrl(8'h70);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(clk_div == 1'b0 && tick == 1'b0, "R1 reset mid-run", {clk_div, tick}, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check(clk_div == 1'b0, "R1 fixed source after second reset", clk_div, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule